// File: doc/BRIEF.md
# Page-Mode DRAM Controller with Row Refresh

This controller connects a single-request host port to an asynchronous DRAM with a shared address bus. Each host request carries a write flag, a full word address and write data. The controller splits the address into a row field (upper bits) and a column field (lower bits). It sends the row first under a falling row strobe. After the activation delay it sends the column under a falling column strobe. During the column phase the write-enable strobe picks a write or a read.

After an access the row stays open. A later request to the same row goes straight to a column cycle. A request to another row closes the open row, waits out the precharge time and then opens the new row. Read data is captured into a holding register at the end of the column phase. It stays valid after the column strobe rises, in extended-data-out style, until the next read finishes.

A free-running interval timer requests one row refresh per interval. A refresh is a row-strobe-only cycle on the next row from a wrapping counter. It takes priority over new host traffic and closes any open row first.

Top module: `dram_page_ctrl`

## Requirements
- R1: After reset, dramRasN, dramCasN and dramWeN are 1, reqReady is 1 and rdValid is 0.
- R2: For an access to reqAddr, dramRasN falls while dramAddr carries the row field reqAddr[ROW_W+COL_W-1:COL_W]. Later dramCasN falls while dramAddr carries the column field reqAddr[COL_W-1:0]. dramCasN is never low while dramRasN is high.
- R3: dramCasN falls at least T_RCD cycles after dramRasN fell, and each column strobe stays low for exactly T_CAS cycles.
- R4: Before every falling edge of dramRasN, dramRasN has been high for at least T_RP cycles.
- R5: While a row is open, a request to the same row causes no new falling edge of dramRasN. Only a column strobe is issued.
- R6: While a row is open, a request to a different row raises dramRasN, precharges, and then makes exactly one new row activation for that access.
- R7: During the column phase of a write, dramWeN is 0 and memWdata equals the request's write data. During a read, dramWeN stays 1.
- R8: Each read produces exactly one single-cycle rdValid pulse. On that pulse, rdData equals the DRAM data present at the end of the column phase. Reads complete in request order.
- R9: rdData stays unchanged from one rdValid pulse until the next, including across writes and refreshes.
- R10: A refresh request arises every REFRESH_INTERVAL cycles. A refresh is a cycle in which dramRasN is low for exactly T_RAS cycles with dramCasN held high.
- R11: Refresh cycles address rows 0, 1, 2, … in order on dramAddr, wrapping to 0 after row 2^ROW_W−1.
- R12: While a refresh is pending, reqReady is 0, and no request is accepted during the row-strobe period of a refresh.
- R13: The block holds one request at a time. In the cycle after a request is accepted (reqValid and reqReady both 1 at a clock edge), reqReady is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Host request present |
| reqReady | output | 1 | Controller can accept a request |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ROW_W+COL_W | Word address, row field in the upper bits |
| reqWdata | input | DATA_W | Write data |
| rdValid | output | 1 | One-cycle pulse per completed read |
| rdData | output | DATA_W | Held read data |
| dramAddr | output | max(ROW_W,COL_W) | Multiplexed row/column address |
| dramRasN | output | 1 | Row strobe, active low |
| dramCasN | output | 1 | Column strobe, active low |
| dramWeN | output | 1 | Write enable, active low |
| memWdata | output | DATA_W | Data to the DRAM |
| memRdata | input | DATA_W | Data from the DRAM |

## Verification
The bench aims at three things. The first is a same-row access that follows a write; a controller without page tracking would re-activate the row, which the bench catches by counting row-strobe falls. The second is a row change; precharge and activation counts would show a skipped precharge or a double activation. The third is a refresh that lands mid-stream; a controller that let it overlap a host access, addressed the wrong row or forgot the wrap would break the per-row order or the interval gap. A read followed by writes and idle time checks that the held read data does not drift; a controller without the holding register would let it follow the DRAM bus.

// File: rtl/dramctl_pkg.sv
package dramctl_pkg;
  typedef enum logic [2:0] {
    ST_IDLE, ST_ACT, ST_COL, ST_OPEN, ST_PRE, ST_REF
  } dramState_t;

  typedef enum logic [1:0] {
    ADDR_ROW, ADDR_COL, ADDR_REF
  } addrSel_t;

  typedef struct packed {
    logic     latchReq;
    logic     latchOpenRow;
    logic     captureRead;
    logic     advRefRow;
    addrSel_t addrSel;
  } dpStrobe_t;
endpackage

// File: rtl/dram_refresh_timer.sv
module dram_refresh_timer #(
  parameter int REFRESH_INTERVAL = 64
) (
  input  logic clk,
  input  logic rstN,
  input  logic refDone,
  output logic refPending
);
  localparam int RT_W = (REFRESH_INTERVAL > 2) ? $clog2(REFRESH_INTERVAL) : 1;

  logic [RT_W-1:0] intervalQ;
  logic            pendQ;
  logic            expire;

  assign expire = (intervalQ == '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      intervalQ <= RT_W'(REFRESH_INTERVAL - 1);
      pendQ     <= 1'b0;
    end else begin
      intervalQ <= expire ? RT_W'(REFRESH_INTERVAL - 1) : intervalQ - 1'b1;
      if (expire)       pendQ <= 1'b1;
      else if (refDone) pendQ <= 1'b0;
    end
  end

  assign refPending = pendQ;

  // R10
  refresh_clears_chk: assert property (@(posedge clk) disable iff (!rstN)
    (refDone && !expire) |=> !refPending);
endmodule

// File: rtl/dram_page_ctrl_dp.sv
module dram_page_ctrl_dp import dramctl_pkg::*; #(
  parameter int ROW_W  = 4,
  parameter int COL_W  = 4,
  parameter int DATA_W = 8
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  dpStrobe_t              strb,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic                   reqWrite,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   pageHit,
  output logic                   isWrite,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData
);
  localparam int AW = ROW_W + COL_W;

  logic [ROW_W-1:0]  reqRowQ, openRowQ, refRowQ;
  logic [COL_W-1:0]  reqColQ;
  logic              isWriteQ;
  logic [DATA_W-1:0] wdataQ, rdDataQ;
  logic              rdValidQ;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      reqRowQ  <= '0;
      reqColQ  <= '0;
      isWriteQ <= 1'b0;
      wdataQ   <= '0;
      openRowQ <= '0;
      refRowQ  <= '0;
      rdDataQ  <= '0;
      rdValidQ <= 1'b0;
    end else begin
      if (strb.latchReq) begin
        reqRowQ  <= reqAddr[AW-1:COL_W];
        reqColQ  <= reqAddr[COL_W-1:0];
        isWriteQ <= reqWrite;
        wdataQ   <= reqWdata;
      end
      if (strb.latchOpenRow) openRowQ <= reqRowQ;
      if (strb.advRefRow)    refRowQ  <= refRowQ + 1'b1;
      if (strb.captureRead)  rdDataQ  <= memRdata;
      rdValidQ <= strb.captureRead;
    end
  end

  always_comb begin
    dramAddr = '0;
    case (strb.addrSel)
      ADDR_COL: dramAddr[COL_W-1:0] = reqColQ;
      ADDR_REF: dramAddr[ROW_W-1:0] = refRowQ;
      default:  dramAddr[ROW_W-1:0] = reqRowQ;
    endcase
  end

  assign pageHit  = (reqAddr[AW-1:COL_W] == openRowQ);
  assign isWrite  = isWriteQ;
  assign memWdata = wdataQ;
  assign rdValid  = rdValidQ;
  assign rdData   = rdDataQ;

  // R8
  rd_single_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    rdValid |=> !rdValid);

  // R11
  ref_row_step_chk: assert property (@(posedge clk) disable iff (!rstN)
    strb.advRefRow |=> (refRowQ == ROW_W'($past(refRowQ) + 1'b1)));
endmodule

// File: rtl/dram_page_ctrl_fsm.sv
module dram_page_ctrl_fsm import dramctl_pkg::*; #(
  parameter int T_RP  = 2,
  parameter int T_RCD = 2,
  parameter int T_CAS = 2,
  parameter int T_RAS = 3
) (
  input  logic      clk,
  input  logic      rstN,
  input  logic      reqValid,
  output logic      reqReady,
  input  logic      refPending,
  input  logic      pageHit,
  input  logic      isWrite,
  output dpStrobe_t strb,
  output logic      refDone,
  output logic      dramRasN,
  output logic      dramCasN,
  output logic      dramWeN
);
  localparam int TW = $clog2(T_RP + T_RCD + T_CAS + T_RAS + 1);

  dramState_t    stateQ, stateD;
  logic [TW-1:0] cntQ, cntD;
  logic          busyQ, busyD;
  logic          accept, tDone;

  assign reqReady = ((stateQ == ST_IDLE) || (stateQ == ST_OPEN)) && !refPending;
  assign accept   = reqValid && reqReady;
  assign tDone    = (cntQ == '0);

  always_comb begin
    stateD = stateQ;
    cntD   = tDone ? cntQ : cntQ - 1'b1;
    busyD  = busyQ || accept;
    case (stateQ)
      ST_IDLE: begin
        if (refPending) begin
          stateD = ST_REF;  cntD = TW'(T_RAS - 1);
        end else if (accept) begin
          stateD = ST_ACT;  cntD = TW'(T_RCD - 1);
        end
      end
      ST_ACT: if (tDone) begin
        stateD = ST_COL;  cntD = TW'(T_CAS - 1);
      end
      ST_COL: if (tDone) begin
        stateD = ST_OPEN; busyD = 1'b0;
      end
      ST_OPEN: begin
        if (refPending || (accept && !pageHit)) begin
          stateD = ST_PRE;  cntD = TW'(T_RP - 1);
        end else if (accept) begin
          stateD = ST_COL;  cntD = TW'(T_CAS - 1);
        end
      end
      ST_PRE: if (tDone) begin
        if (refPending) begin
          stateD = ST_REF;  cntD = TW'(T_RAS - 1);
        end else if (busyQ) begin
          stateD = ST_ACT;  cntD = TW'(T_RCD - 1);
        end else begin
          stateD = ST_IDLE;
        end
      end
      ST_REF: if (tDone) begin
        stateD = ST_PRE;  cntD = TW'(T_RP - 1);
      end
      default: stateD = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      stateQ <= ST_IDLE;
      cntQ   <= '0;
      busyQ  <= 1'b0;
    end else begin
      stateQ <= stateD;
      cntQ   <= cntD;
      busyQ  <= busyD;
    end
  end

  assign dramRasN = !((stateQ == ST_ACT) || (stateQ == ST_COL) ||
                      (stateQ == ST_OPEN) || (stateQ == ST_REF));
  assign dramCasN = (stateQ != ST_COL);
  assign dramWeN  = !((stateQ == ST_COL) && isWrite);

  always_comb begin
    strb.latchReq     = accept;
    strb.latchOpenRow = (stateQ == ST_ACT);
    strb.captureRead  = (stateQ == ST_COL) && tDone && !isWrite;
    strb.advRefRow    = (stateQ == ST_REF) && tDone;
    case (stateQ)
      ST_COL:  strb.addrSel = ADDR_COL;
      ST_REF:  strb.addrSel = ADDR_REF;
      default: strb.addrSel = ADDR_ROW;
    endcase
  end
  assign refDone = strb.advRefRow;

  // Strobe run-length counters for the timing checks
  logic [TW-1:0] highRun, lowRun;
  always_ff @(posedge clk) begin
    if (!rstN) begin
      highRun <= TW'(T_RP);
      lowRun  <= '0;
    end else begin
      highRun <= !dramRasN ? '0 : ((highRun >= TW'(T_RP)) ? highRun : highRun + 1'b1);
      lowRun  <=  dramRasN ? '0 : ((lowRun >= TW'(T_RCD)) ? lowRun : lowRun + 1'b1);
    end
  end

  // R2
  cas_needs_ras_chk: assert property (@(posedge clk) disable iff (!rstN)
    !dramCasN |-> !dramRasN);

  // R4
  precharge_time_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramRasN) |-> (highRun >= TW'(T_RP)));

  // R3
  ras_to_cas_chk: assert property (@(posedge clk) disable iff (!rstN)
    $fell(dramCasN) |-> (lowRun >= TW'(T_RCD)));

  // R12
  refresh_blocks_ready_chk: assert property (@(posedge clk) disable iff (!rstN)
    refPending |-> !reqReady);

  // R13
  one_in_flight_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady) |=> !reqReady);
endmodule

// File: rtl/dram_page_ctrl.sv
module dram_page_ctrl import dramctl_pkg::*; #(
  parameter int ROW_W            = 4,
  parameter int COL_W            = 4,
  parameter int DATA_W           = 8,
  parameter int T_RP             = 2,
  parameter int T_RCD            = 2,
  parameter int T_CAS            = 2,
  parameter int T_RAS            = 3,
  parameter int REFRESH_INTERVAL = 64
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   reqValid,
  output logic                   reqReady,
  input  logic                   reqWrite,
  input  logic [ROW_W+COL_W-1:0] reqAddr,
  input  logic [DATA_W-1:0]      reqWdata,
  output logic                   rdValid,
  output logic [DATA_W-1:0]      rdData,
  output logic [((ROW_W > COL_W) ? ROW_W : COL_W)-1:0] dramAddr,
  output logic                   dramRasN,
  output logic                   dramCasN,
  output logic                   dramWeN,
  output logic [DATA_W-1:0]      memWdata,
  input  logic [DATA_W-1:0]      memRdata
);
  dpStrobe_t strb;
  logic      refPending, refDone, pageHit, isWrite;

  dram_refresh_timer #(.REFRESH_INTERVAL(REFRESH_INTERVAL)) u_timer (
    .clk(clk), .rstN(rstN), .refDone(refDone), .refPending(refPending)
  );

  dram_page_ctrl_fsm #(.T_RP(T_RP), .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS)) u_fsm (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .refPending(refPending), .pageHit(pageHit), .isWrite(isWrite),
    .strb(strb), .refDone(refDone),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN)
  );

  dram_page_ctrl_dp #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W)) u_dp (
    .clk(clk), .rstN(rstN), .strb(strb),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqWdata(reqWdata),
    .pageHit(pageHit), .isWrite(isWrite),
    .dramAddr(dramAddr), .memWdata(memWdata), .memRdata(memRdata),
    .rdValid(rdValid), .rdData(rdData)
  );
endmodule

// File: tb/dram_page_ctrl_bench.sv
`timescale 1ns/1ps
module dram_page_ctrl_bench;
  localparam int ROW_W = 4, COL_W = 4, DATA_W = 8;
  localparam int T_RP = 2, T_RCD = 2, T_CAS = 2, T_RAS = 3, INTERVAL = 64;
  localparam int AW = ROW_W + COL_W;
  localparam int MA_W = (ROW_W > COL_W) ? ROW_W : COL_W;
  localparam int ROWS = 1 << ROW_W;
  localparam int SLACK = 16;

  logic clk = 0, rstN = 0;
  logic reqValid = 0, reqWrite = 0;
  logic [AW-1:0] reqAddr = '0;
  logic [DATA_W-1:0] reqWdata = '0;
  logic reqReady, rdValid, dramRasN, dramCasN, dramWeN;
  logic [DATA_W-1:0] rdData, memWdata, memRdata;
  logic [MA_W-1:0] dramAddr;

  always #2 clk = ~clk;

  dram_page_ctrl #(.ROW_W(ROW_W), .COL_W(COL_W), .DATA_W(DATA_W), .T_RP(T_RP),
    .T_RCD(T_RCD), .T_CAS(T_CAS), .T_RAS(T_RAS), .REFRESH_INTERVAL(INTERVAL)) u_dram_page_ctrl (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqWrite(reqWrite), .reqAddr(reqAddr), .reqWdata(reqWdata),
    .rdValid(rdValid), .rdData(rdData), .dramAddr(dramAddr),
    .dramRasN(dramRasN), .dramCasN(dramCasN), .dramWeN(dramWeN),
    .memWdata(memWdata), .memRdata(memRdata));

  int testsRun = 0, testsFailed = 0;
  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    testsRun++;
    if (!ok) begin
      testsFailed++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // ---------------- DRAM model (sampled on falling clock edge) -------------
  logic [DATA_W-1:0] cells [1<<AW];
  logic [DATA_W-1:0] shadow [1<<AW];
  logic [ROW_W-1:0] rowLatch = '0;
  logic [COL_W-1:0] colLatch = '0;
  logic prevRas = 1, prevCas = 1;
  int cyc = 0, highStart = -100, lowStart = 0, casStart = 0, lastRefStart = 0;
  int rasFalls = 0, refCount = 0, refExp = 0;
  bit casSeen = 0, readyWhileLow = 0;
  logic [ROW_W-1:0] expRow = '0;
  logic [COL_W-1:0] expCol = '0;
  bit expWrite = 0;
  logic [DATA_W-1:0] expData = '0;

  assign memRdata = (!dramCasN && dramWeN) ? cells[{rowLatch, colLatch}] : '0;

  initial for (int i = 0; i < (1<<AW); i++) begin cells[i] = '0; shadow[i] = '0; end

  always @(negedge clk) begin
    cyc <= cyc + 1;
    if (rstN) begin
      if (prevRas && !dramRasN) begin
        chk(cyc - highStart >= T_RP, "R4", "precharge cycles", cyc - highStart, T_RP);
        rowLatch <= dramAddr[ROW_W-1:0];
        lowStart <= cyc; casSeen <= 0; readyWhileLow <= 0;
        rasFalls <= rasFalls + 1;
      end
      if (!dramRasN && reqReady && !casSeen && !(prevRas && !dramRasN)) readyWhileLow <= 1;
      if (prevCas && !dramCasN) begin
        casSeen <= 1; casStart <= cyc;
        chk(!dramRasN, "R2", "row strobe low at column strobe", dramRasN, 0);
        chk(rowLatch == expRow, "R2", "latched row", rowLatch, expRow);
        chk(dramAddr[COL_W-1:0] == expCol, "R2", "column address", dramAddr[COL_W-1:0], expCol);
        chk(cyc - lowStart >= T_RCD, "R3", "row-to-column cycles", cyc - lowStart, T_RCD);
        chk(dramWeN == !expWrite, "R7", "write enable", dramWeN, !expWrite);
        colLatch <= dramAddr[COL_W-1:0];
        if (!dramWeN) begin
          chk(memWdata == expData, "R7", "write data", memWdata, expData);
          cells[{rowLatch, dramAddr[COL_W-1:0]}] <= memWdata;
        end
      end
      if (!prevCas && dramCasN)
        chk(cyc - casStart == T_CAS, "R3", "column strobe width", cyc - casStart, T_CAS);
      if (!prevRas && dramRasN) begin
        highStart <= cyc;
        if (!casSeen) begin
          chk(rowLatch == refExp[ROW_W-1:0], "R11", "refresh row", rowLatch, refExp);
          chk(cyc - lowStart == T_RAS, "R10", "refresh strobe width", cyc - lowStart, T_RAS);
          chk(!readyWhileLow, "R12", "ready during refresh", readyWhileLow, 0);
          if (refCount > 0)
            chk(lowStart - lastRefStart <= INTERVAL + SLACK, "R10", "refresh gap",
                lowStart - lastRefStart, INTERVAL);
          lastRefStart <= lowStart;
          refExp <= (refExp + 1) % ROWS;
          refCount <= refCount + 1;
        end
      end
    end
    prevRas <= dramRasN; prevCas <= dramCasN;
  end

  // ---------------- Scoreboard monitor ----------------
  logic [DATA_W-1:0] expQ[$];
  logic [DATA_W-1:0] lastRd = '0;
  bit haveRd = 0, prevRdValid = 0;
  int edoBad = 0;
  always @(negedge clk) begin
    if (rstN) begin
      if (rdValid) begin
        chk(!prevRdValid, "R8", "single-cycle rdValid", prevRdValid, 0);
        if (expQ.size() == 0) chk(0, "R8", "unexpected read", rdData, 0);
        else begin
          logic [DATA_W-1:0] e;
          e = expQ.pop_front();
          chk(rdData == e, "R8", "read data", rdData, e);
        end
        lastRd = rdData; haveRd = 1;
      end else if (haveRd && rdData != lastRd) edoBad++;
      prevRdValid = rdValid;
    end
  end

  // ---------------- Driver ----------------
  int lastRasDelta = 0;
  task automatic access(input bit wr, input logic [AW-1:0] a, input logic [DATA_W-1:0] d);
    int rasAtAccept;
    @(negedge clk);
    reqValid = 1; reqWrite = wr; reqAddr = a; reqWdata = d;
    while (!reqReady) @(negedge clk);
    expRow = a[AW-1:COL_W]; expCol = a[COL_W-1:0]; expWrite = wr; expData = d;
    if (wr) shadow[a] = d; else expQ.push_back(shadow[a]);
    rasAtAccept = rasFalls;
    @(negedge clk);
    reqValid = 0;
    chk(!reqReady, "R13", "ready after accept", reqReady, 0);
    while (!reqReady) @(negedge clk);
    lastRasDelta = rasFalls - rasAtAccept;
  endtask

  task automatic freshWindow();
    int r;
    r = refCount;
    while (refCount == r) @(negedge clk);
    while (!reqReady) @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    chk(0, "ALL", "watchdog expired", 0, 1);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end

  initial begin
    logic [7:0] lfsr;
    logic [DATA_W-1:0] held;
    int r0;
    repeat (3) @(negedge clk);
    rstN = 1;
    @(negedge clk);
    // R1 reset state
    chk(dramRasN && dramCasN && dramWeN, "R1", "strobes idle", {dramRasN, dramCasN, dramWeN}, 7);
    chk(reqReady, "R1", "ready after reset", reqReady, 1);
    chk(!rdValid, "R1", "rdValid after reset", rdValid, 0);

    // R5 page hit after write
    freshWindow();
    access(1, 8'h35, 8'hA7);
    chk(lastRasDelta == 1, "R2", "activation for first access", lastRasDelta, 1);
    access(0, 8'h35, 8'h00);
    chk(lastRasDelta == 0, "R5", "same-row read activations", lastRasDelta, 0);
    access(0, 8'h3C, 8'h00);
    chk(lastRasDelta == 0, "R5", "same-row other column", lastRasDelta, 0);
    // R6 row miss
    access(1, 8'h72, 8'h5E);
    chk(lastRasDelta == 1, "R6", "row-miss activations", lastRasDelta, 1);
    access(0, 8'h72, 8'h00);
    chk(lastRasDelta == 0, "R5", "hit after miss", lastRasDelta, 0);

    // R9 held read data across writes and idle time
    freshWindow();
    access(0, 8'h72, 8'h00);
    held = rdData;
    access(1, 8'h11, 8'hC3);
    access(1, 8'hF0, 8'h99);
    repeat (30) @(negedge clk);
    chk(rdData == held, "R9", "read data held", rdData, held);

    // mixed traffic with refresh interleaved (R8, R10, R11)
    lfsr = 8'h5B;
    for (int i = 0; i < 120; i++) begin
      lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
      access(lfsr[0], {lfsr[7:6], 2'b00, lfsr[4:1]}, lfsr ^ 8'h3A);
    end

    // idle refresh sweep with wrap (R10, R11)
    r0 = refCount;
    repeat (20 * INTERVAL) @(negedge clk);
    chk(refCount - r0 >= 19, "R10", "refreshes in idle window", refCount - r0, 20);
    chk(refCount > ROWS, "R11", "row counter wrapped", refCount, ROWS + 1);

    repeat (10) @(negedge clk);
    chk(expQ.size() == 0, "R8", "reads outstanding", expQ.size(), 0);
    chk(edoBad == 0, "R9", "read data changed between pulses", edoBad, 0);
    $display("[TB] %0d tests run, %0d failed", testsRun, testsFailed);
    $finish;
  end
endmodule